// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer with a small register port. A 12-bit down-counter advances on a 256 Hz tick, which is produced by dividing a 32768 Hz enable strobe by 128. Software keeps the system alive by writing a keyed restart command. That command reloads the counter, but only a restart that arrives once the count has fallen to or below a programmable delta is accepted as on time. A restart that comes earlier is a window error. A count that runs out is an underflow. Either fault is recorded in a status register. Depending on the mode, a fault also drives an interrupt line and pulses one of two reset requests: a full system reset or a processor-only reset.

The mode register accepts a single write after reset. Its first write also reloads the counter, and all later writes are dropped. A watchdog left enabled by that write therefore cannot be turned off by software. Two halt controls freeze the timebase: one for a debug-halt input and one for an idle input, each gated by its own mode bit.

The register port takes one request per cycle with no back-pressure, so there is no ready signal. A read returns its data one cycle after the request, marked by `bus_rvalid`. Writes take effect at the clock edge that samples them.

Top module: `win_watchdog`

## Requirements
- R1: After reset the mode register reads 0x3FFF2FFF, the status register reads 0, `irq_o`, `sys_rst_req` and `cpu_rst_req` are low, and the counter holds 0xFFF.
- R2: Word address 0 is the control register (write only, reads 0), address 1 is the mode register and address 2 is the status register. Read data appears with `bus_rvalid` in the cycle after the request. Mode fields are: reload [11:0], interrupt enable bit 12, reset enable bit 13, processor-only select bit 14, disable bit 15, delta [27:16], halt-in-debug bit 28 and halt-in-idle bit 29. Bits 31:30 read 0.
- R3: Only the first mode write after reset is stored, and that write reloads the counter with its own reload value. Every later mode write leaves both the mode register and the counter unchanged.
- R4: The counter decrements once every 128 `slow_en` pulses. After a reload with value R and with `slow_en` high every cycle, the underflow is recorded at the 128·(R+1)-th clock edge after the reloading edge. The counter then reloads with R and runs on.
- R5: A control write with 0xA5 in bits [31:24] and bit 0 set is a restart. It reloads the counter and clears the prescaler. A control write with any other key, or with bit 0 clear, has no effect.
- R6: A restart sampled while the counter is above the delta raises a window error and still reloads the counter. A restart at or below the delta raises no fault.
- R7: Status bit 0 records underflow and bit 1 records window error. Each bit holds until a status read clears it. A fault in the same cycle as the read stays set.
- R8: `irq_o` is high while the interrupt enable is set and any status bit is set. With the interrupt enable clear it stays low.
- R9: When the reset enable is set, each fault gives a one-cycle pulse in the next cycle. The pulse goes on `sys_rst_req` when the processor-only select is 0 and on `cpu_rst_req` when it is 1. The two never pulse together.
- R10: With the disable bit set, the prescaler and counter do not run, no fault is raised, and restarts are ignored.
- R11: `dbg_halt` with bit 28 set, or `idle_in` with bit 29 set, freezes the prescaler and the counter. Without its enable bit, each input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle strobe at 32768 Hz |
| dbg_halt | input | 1 | Processor is halted in debug |
| idle_in | input | 1 | Processor is idle |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_o | output | 1 | Fault interrupt |
| sys_rst_req | output | 1 | Full reset request pulse |
| cpu_rst_req | output | 1 | Processor-only reset request pulse |

## Verification
Restarts are placed at three points: before the window opens (window error), inside it (no fault, underflow pushed back by a full period), and not at all (underflow on the predicted edge). These placements separate the delta compare from the reload path. Malformed keys and a missing restart bit are sent in the middle of a period, and the underflow must land exactly where it would have without them. Separate configurations cover disable, interrupt gating, processor-only reset and each halt input with and without its enable bit. For the halt cases, the fault time moves by exactly the frozen span only when the enable bit is set.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W   = 12;
  localparam int BUS_W   = 32;
  localparam int MODE_W  = 30;
  localparam int KEY_W   = 8;
  localparam int KEY_LSB = 24;
  localparam logic [KEY_W-1:0]  RESTART_KEY = 8'hA5;
  localparam logic [MODE_W-1:0] MODE_RST    = 30'h3FFF_2FFF;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Packed layout matches the mode word bit for bit (MSB first).
  typedef struct packed {
    logic             halt_idle;  // 29
    logic             halt_dbg;   // 28
    logic [CNT_W-1:0] delta;      // 27:16
    logic             dis;        // 15
    logic             proc_only;  // 14
    logic             rst_en;     // 13
    logic             irq_en;     // 12
    logic [CNT_W-1:0] reload;     // 11:0
  } mode_t;
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_en,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else if (run && slow_en) begin
      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
  end

  assign tick = run && slow_en && !clr && (pre_q == LAST);
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             restart_ok,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] delta,
  output logic [CNT_W-1:0] cnt_q,
  output logic             unf_evt,
  output logic             win_evt
);
  // Early restart: count still above the window bound.
  assign win_evt = restart_ok && (cnt_q > delta);
  assign unf_evt = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             unf_evt,
  input  logic             win_evt,
  output mode_t            mode_q,
  output logic             locked_q,
  output logic             mode_wr_ok,
  output logic [CNT_W-1:0] new_reload,
  output logic             restart_req,
  output logic [1:0]       stat_q,
  output logic [BUS_W-1:0] rdata_q,
  output logic             rvalid_q
);
  reg_sel_e         sel;
  logic             wr, rd, stat_rd;
  logic [BUS_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign stat_rd = rd && (sel == REG_STAT);

  assign mode_wr_ok  = wr && (sel == REG_MODE) && !locked_q;
  assign new_reload  = bus_wdata[CNT_W-1:0];
  assign restart_req = wr && (sel == REG_CTRL) && bus_wdata[0] &&
                       (bus_wdata[KEY_LSB +: KEY_W] == RESTART_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= mode_t'(MODE_RST);
      locked_q <= 1'b0;
    end else if (mode_wr_ok) begin
      mode_q   <= mode_t'(bus_wdata[MODE_W-1:0]);
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_rd ? 2'b00 : stat_q) | {win_evt, unf_evt};
  end

  always_comb begin
    case (sel)
      REG_MODE: rd_mux = {{(BUS_W-MODE_W){1'b0}}, mode_q};
      REG_STAT: rd_mux = {{(BUS_W-2){1'b0}}, stat_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rd ? rd_mux : '0;
      rvalid_q <= rd;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int PRE_DIV = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic             dbg_halt,
  input  logic             idle_in,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  output logic             irq_o,
  output logic             sys_rst_req,
  output logic             cpu_rst_req
);
  mode_t            mode_q;
  logic             locked_q, mode_wr_ok, restart_req, restart_ok;
  logic [CNT_W-1:0] new_reload, load_val, cnt_q;
  logic [1:0]       stat_q;
  logic             halted, run, tick, cnt_load;
  logic             unf_evt, win_evt, fault;

  wwd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .unf_evt(unf_evt), .win_evt(win_evt),
    .mode_q(mode_q), .locked_q(locked_q),
    .mode_wr_ok(mode_wr_ok), .new_reload(new_reload),
    .restart_req(restart_req), .stat_q(stat_q),
    .rdata_q(bus_rdata), .rvalid_q(bus_rvalid)
  );

  assign restart_ok = restart_req && !mode_q.dis;
  assign cnt_load   = mode_wr_ok || restart_ok;
  assign load_val   = mode_wr_ok ? new_reload : mode_q.reload;
  assign halted     = (dbg_halt && mode_q.halt_dbg) ||
                      (idle_in  && mode_q.halt_idle);
  assign run        = !mode_q.dis && !halted;

  wwd_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
    .run(run), .clr(cnt_load), .tick(tick)
  );

  wwd_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .restart_ok(restart_ok), .load_val(load_val),
    .reload(mode_q.reload), .delta(mode_q.delta),
    .cnt_q(cnt_q), .unf_evt(unf_evt), .win_evt(win_evt)
  );

  assign fault = unf_evt || win_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req <= 1'b0;
      cpu_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= fault && mode_q.rst_en && !mode_q.proc_only;
      cpu_rst_req <= fault && mode_q.rst_en &&  mode_q.proc_only;
    end
  end

  assign irq_o = mode_q.irq_en && (stat_q != 2'b00);
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
  import wwd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              locked_q,
  input logic [MODE_W-1:0] mode_word,
  input logic              dis,
  input logic              halted,
  input logic              cnt_load,
  input logic              mode_wr_ok,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              unf_evt,
  input logic              win_evt,
  input logic [1:0]        stat_q,
  input logic              irq_o,
  input logic              sys_rst_req,
  input logic              cpu_rst_req
);
  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_word));

  assert_dis_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> (!unf_evt && !win_evt));

  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !cnt_load) |=> $stable(cnt_q));

  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> stat_q[0]);

  assert_win_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |=> stat_q[1]);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(unf_evt || win_evt || mode_wr_ok));

  assert_rst_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req && cpu_rst_req));

  assert_rst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req || cpu_rst_req) |-> $past(unf_evt || win_evt));
endmodule

bind win_watchdog wwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .locked_q(locked_q), .mode_word(mode_q),
  .dis(mode_q.dis), .halted(halted), .cnt_load(cnt_load),
  .mode_wr_ok(mode_wr_ok), .cnt_q(cnt_q), .unf_evt(unf_evt),
  .win_evt(win_evt), .stat_q(stat_q), .irq_o(irq_o),
  .sys_rst_req(sys_rst_req), .cpu_rst_req(cpu_rst_req)
);

// File: tb/test_win_watchdog.sv
module test_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;
  localparam int DIVP       = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b1, dbg_halt = 1'b0, idle_in = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_o, sys_rst_req, cpu_rst_req;

  int checks = 0, errors = 0, n_sys = 0, n_cpu = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog i_win_watchdog (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .dbg_halt(dbg_halt),
    .idle_in(idle_in), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_o(irq_o), .sys_rst_req(sys_rst_req),
    .cpu_rst_req(cpu_rst_req)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin n_sys = 0; n_cpu = 0; end
    else begin
      if (sys_rst_req) n_sys++;
      if (cpu_rst_req) n_cpu++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; occupies exactly one cycle.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    dbg_halt = 1'b0; idle_in = 1'b0; bus_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int rl, input int dl, input bit ie, input bit re,
                                     input bit po, input bit ds, input bit hd, input bit hi);
    return {2'b00, hi, hd, 12'(dl), ds, po, re, ie, 12'(rl)};
  endfunction

  localparam logic [31:0] RESTART = 32'hA500_0001;
  localparam int T5 = DIVP * 6;

  initial begin
    do_reset();
    // R1 reset state
    check(32'(irq_o), 0, "R1 irq after reset");
    check(32'(sys_rst_req | cpu_rst_req), 0, "R1 reset reqs after reset");
    rd_expect(2'd1, 32'h3FFF_2FFF, "R1 mode reset value");
    rd_expect(2'd2, 32'h0, "R1 status reset value");
    rd_expect(2'd0, 32'h0, "R2 control reads zero");

    // R2/R3 register map and write-once
    wr(2'd1, mk(5, 5, 1, 1, 0, 0, 1, 1));
    rd_expect(2'd1, mk(5, 5, 1, 1, 0, 0, 1, 1), "R2 mode readback");
    wr(2'd1, mk(9, 2, 0, 0, 1, 1, 0, 0));
    rd_expect(2'd1, mk(5, 5, 1, 1, 0, 0, 1, 1), "R3 second mode write ignored");

    // R4 timeout, R8 irq, R9 full reset pulse
    wr(2'd0, RESTART);
    cycles(T5 - 2);
    check(32'(irq_o), 0, "R4 no fault before timeout");
    cycles(3);
    check(32'(irq_o), 1, "R4/R8 underflow raises irq");
    check(32'(n_sys), 1, "R9 one full reset pulse");
    check(32'(n_cpu), 0, "R9 no cpu reset pulse");
    rd_expect(2'd2, 32'h1, "R7 underflow bit");
    rd_expect(2'd2, 32'h0, "R7 cleared by read");
    check(32'(irq_o), 0, "R8 irq drops after clear");

    // R5 wrong key and missing bit ignored
    wr(2'd0, RESTART);
    cycles(400);
    wr(2'd0, 32'h5A00_0001);
    wr(2'd0, 32'hA500_0000);
    cycles(T5 - 2 - 402);
    check(32'(irq_o), 0, "R5 no fault before original timeout");
    cycles(3);
    check(32'(irq_o), 1, "R5 bad restarts did not reload");
    rd_expect(2'd2, 32'h1, "R5 underflow only");

    // R5/R6 in-window restart pushes the timeout out
    wr(2'd0, RESTART);
    cycles(600);
    wr(2'd0, RESTART);
    cycles(T5 - 2);
    check(32'(irq_o), 0, "R5 restart extended timeout");
    cycles(3);
    check(32'(irq_o), 1, "R5 fault after extended timeout");
    rd_expect(2'd2, 32'h1, "R6 in-window restart no window error");

    // R6 window error, R9 processor-only reset
    do_reset();
    wr(2'd1, mk(20, 5, 1, 1, 1, 0, 1, 1));
    wr(2'd0, RESTART);
    cycles(2);
    check(32'(irq_o), 1, "R6 early restart irq");
    check(32'(n_cpu), 1, "R9 cpu reset pulse");
    check(32'(n_sys), 0, "R9 no full reset with proc select");
    rd_expect(2'd2, 32'h2, "R6 window error bit");
    cycles(DIVP * 15 + 10);
    wr(2'd0, RESTART);
    cycles(2);
    rd_expect(2'd2, 32'h0, "R6 restart at delta accepted");
    check(32'(n_cpu), 1, "R6 no extra fault pulse");

    // R8 irq disabled
    do_reset();
    wr(2'd1, mk(5, 5, 0, 1, 0, 0, 1, 1));
    cycles(T5 + 3);
    check(32'(irq_o), 0, "R8 irq masked");
    check(32'(n_sys), 1, "R9 reset pulse without irq");
    rd_expect(2'd2, 32'h1, "R8 status still records");

    // R10 disabled
    do_reset();
    wr(2'd1, mk(3, 0, 1, 1, 0, 1, 1, 1));
    wr(2'd0, RESTART);
    cycles(2000);
    check(32'(irq_o), 0, "R10 disabled irq");
    check(32'(n_sys + n_cpu), 0, "R10 disabled reset pulses");
    rd_expect(2'd2, 32'h0, "R10 disabled status");

    // R11 debug halt freezes, idle ignored without its enable
    do_reset();
    wr(2'd1, mk(5, 5, 1, 1, 0, 0, 1, 0));
    dbg_halt = 1'b1;
    cycles(1000);
    check(32'(irq_o), 0, "R11 frozen during debug halt");
    dbg_halt = 1'b0; idle_in = 1'b1;
    cycles(T5 - 2);
    check(32'(irq_o), 0, "R11 timeout shifted by halt span");
    cycles(3);
    check(32'(irq_o), 1, "R11 idle ignored without enable");

    // R11 idle halt freezes, debug ignored without its enable
    do_reset();
    wr(2'd1, mk(5, 5, 1, 1, 0, 0, 0, 1));
    idle_in = 1'b1; dbg_halt = 1'b1;
    cycles(1000);
    check(32'(irq_o), 0, "R11 frozen during idle");
    idle_in = 1'b0;
    cycles(T5 - 2);
    check(32'(irq_o), 0, "R11 idle timeout shifted");
    cycles(3);
    check(32'(irq_o), 1, "R11 debug ignored without enable");
    dbg_halt = 1'b0;

    cycles(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule